// File: doc/BRIEF.md
# Three-Level T-Type Leg Commutation Sequencer

This block drives the four gates of one leg of a three-level T-type inverter. `q1_pos` ties the switch node to the positive rail and `q2_neg` ties it to the negative rail. The back-to-back middle pair, `q3_mid` and `q4_mid`, ties it to the neutral point. The controller asks for an output level on `req_lvl` and gives a dead-time length on `dead_cycles`. The block then walks the gates through safe intermediate states.

In every move, the middle switch shared by the source level and the target level stays on. The switch being released opens first. After the dead time, the switch that completes the target level closes. Because each move follows this break-then-make rule, the same sequence is safe for either direction of load current, so the block has no current-sense input.

A direct request between the two rails is split into two moves that pass through neutral. A synchronous `force_off` input clears all gates at once. When `force_off` is released, the leg restarts by bringing up the neutral connection.

Top module: `tleg_sequencer`

## Requirements
- R1: While `rst_n` is low (synchronous), or on the first clock edge at which `force_off` is high and for as long as it stays high, all four gates are 0 and `busy` is 0. This holds even in the middle of a sequence.
- R2: On the first edge with `rst_n` high and `force_off` low after an all-off state, `q3_mid` turns on. `q4_mid` turns on `dead_cycles` edges later, which makes the leg neutral. `busy` is 1 in between.
- R3: Positive to neutral: `q1_pos` turns off first, then `q4_mid` turns on after the dead time. `q3_mid` stays on throughout.
- R4: Neutral to positive: `q4_mid` turns off first, then `q1_pos` turns on after the dead time. `q3_mid` stays on throughout.
- R5: Neutral to negative: `q3_mid` turns off first, then `q2_neg` turns on after the dead time. `q4_mid` stays on throughout.
- R6: Negative to neutral: `q2_neg` turns off first, then `q3_mid` turns on after the dead time. `q4_mid` stays on throughout.
- R7: A request between positive and negative is done as two moves through neutral, each with its own dead time. Between the two moves, neutral is held for exactly one idle cycle with `busy` 0.
- R8: The off-gap of each move lasts exactly `dead_cycles` clock cycles. A value of 0 counts as 1. The value is captured on the edge that starts the move, so later changes do not affect a move in progress.
- R9: While `busy` is 1, changes on `req_lvl` are ignored. The block samples a new request only once it is idle, and it keeps the gates unchanged while the request equals the present level.
- R10: Level encoding on `req_lvl`: 2'b01 is positive (`q1_pos`,`q3_mid` on), 2'b00 and 2'b11 are neutral (`q3_mid`,`q4_mid` on), and 2'b10 is negative (`q2_neg`,`q4_mid` on).
- R11: `q1_pos` and `q2_neg` are never on together.
- R12: `q3_mid` and `q4_mid` never change in the same cycle, except when the leg is forced off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_off | input | 1 | Synchronous all-gates-off request |
| req_lvl | input | 2 | Requested output level |
| dead_cycles | input | DT_W | Dead-time length in clock cycles |
| q1_pos | output | 1 | Gate of the positive-rail switch |
| q2_neg | output | 1 | Gate of the negative-rail switch |
| q3_mid | output | 1 | Gate of the middle switch on the positive-level side |
| q4_mid | output | 1 | Gate of the middle switch on the negative-level side |
| busy | output | 1 | A move or the start-up sequence is in progress |

## Verification
The hardest situations to reach from the ports are a move whose inputs change while its dead time is running, and a forced shutdown during that same window. In a directed test, `req_lvl` and `dead_cycles` are changed one cycle after a move starts. The test then confirms that the move still ends at the original target after the originally captured delay. Another test raises `force_off` in the middle of a wait and checks that the leg restarts through the neutral bring-up. A rail-to-rail request is run in both directions so that the two-step path through neutral, including its one idle cycle, is timed edge by edge.

// File: rtl/tleg_sequencer.sv
module tleg_sequencer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_off,
  input  logic [1:0]      req_lvl,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            q1_pos,
  output logic            q2_neg,
  output logic            q3_mid,
  output logic            q4_mid,
  output logic            busy
);
  localparam logic [1:0] G1 = 2'd0;
  localparam logic [1:0] G2 = 2'd1;
  localparam logic [1:0] G3 = 2'd2;
  localparam logic [1:0] G4 = 2'd3;

  typedef enum logic [1:0] {L_OFF, L_POS, L_NEU, L_NEG} lvl_t;

  logic [3:0]      gate;
  lvl_t            lvl, tgt, want;
  logic [1:0]      pend;
  logic [DT_W-1:0] cnt, dt_eff;

  assign want   = (req_lvl == 2'b01) ? L_POS : (req_lvl == 2'b10) ? L_NEG : L_NEU;
  assign dt_eff = (dead_cycles == '0) ? DT_W'(1) : dead_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n || force_off) begin
      gate <= '0;
      lvl  <= L_OFF;
      tgt  <= L_OFF;
      pend <= G1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt <= DT_W'(1)) begin
        gate[pend] <= 1'b1;
        lvl        <= tgt;
        busy       <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (lvl == L_OFF) begin
      gate[G3] <= 1'b1;
      pend     <= G4;
      tgt      <= L_NEU;
      cnt      <= dt_eff;
      busy     <= 1'b1;
    end else if (want != lvl) begin
      cnt  <= dt_eff;
      busy <= 1'b1;
      tgt  <= L_NEU;
      case (lvl)
        L_POS: begin
          gate[G1] <= 1'b0;
          pend     <= G4;
        end
        L_NEG: begin
          gate[G2] <= 1'b0;
          pend     <= G3;
        end
        default: begin
          if (want == L_POS) begin
            gate[G4] <= 1'b0;
            pend     <= G1;
            tgt      <= L_POS;
          end else begin
            gate[G3] <= 1'b0;
            pend     <= G2;
            tgt      <= L_NEG;
          end
        end
      endcase
    end
  end

  assign q1_pos = gate[G1];
  assign q2_neg = gate[G2];
  assign q3_mid = gate[G3];
  assign q4_mid = gate[G4];
endmodule

module tleg_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic force_off,
  input logic q1_pos,
  input logic q2_neg,
  input logic q3_mid,
  input logic q4_mid,
  input logic busy
);
  assert_no_rail_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_pos && q2_neg));

  assert_mid_not_together_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(force_off)) |->
      !((q3_mid != $past(q3_mid)) && (q4_mid != $past(q4_mid))));

  assert_pos_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q1_pos) |-> (q3_mid && $past(q3_mid) && !$past(q4_mid)));

  assert_neg_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q2_neg) |-> (q4_mid && $past(q4_mid) && !$past(q3_mid)));

  assert_neutral_from_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q4_mid) |-> !$past(q1_pos));

  assert_neutral_from_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q3_mid) |-> !$past(q2_neg));

  assert_idle_pattern_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({q4_mid, q3_mid, q2_neg, q1_pos} inside {4'b0000, 4'b0101, 4'b1100, 4'b1010}));

  assert_forced_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !(q1_pos || q2_neg || q3_mid || q4_mid || busy));
endmodule

bind tleg_sequencer tleg_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .force_off(force_off),
  .q1_pos(q1_pos), .q2_neg(q2_neg), .q3_mid(q3_mid), .q4_mid(q4_mid), .busy(busy)
);

// File: tb/tb_tleg_sequencer.sv
`timescale 1ns/1ps
module tb_tleg_sequencer;
  localparam int DT_W = 8;
  localparam logic [3:0] P_OFF = 4'b0000, P_POS = 4'b0101, P_NEU = 4'b1100, P_NEG = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_off = 1'b0;
  logic [1:0] req_lvl = 2'b00;
  logic [DT_W-1:0] dead_cycles = 8'd3;
  logic q1_pos, q2_neg, q3_mid, q4_mid, busy;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tleg_sequencer #(.DT_W(DT_W)) dut (
    .clk(clk), .rst_n(rst_n), .force_off(force_off), .req_lvl(req_lvl),
    .dead_cycles(dead_cycles), .q1_pos(q1_pos), .q2_neg(q2_neg),
    .q3_mid(q3_mid), .q4_mid(q4_mid), .busy(busy)
  );

  task automatic chk(input logic [3:0] eg, input logic eb, input string tag);
    logic [3:0] g;
    g = {q4_mid, q3_mid, q2_neg, q1_pos};
    checks++;
    if (g !== eg || busy !== eb) begin
      errors++;
      $display("FAIL %s: gates=%b busy=%b expected gates=%b busy=%b", tag, g, busy, eg, eb);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic move(input logic [1:0] r, input int dt, input logic [3:0] mid,
                      input logic [3:0] fin, input string tag);
    req_lvl = r;
    dead_cycles = DT_W'(dt);
    tick(1);
    chk(mid, 1'b1, tag);
    for (int i = 1; i < ((dt == 0) ? 1 : dt); i++) begin
      tick(1);
      chk(mid, 1'b1, tag);
    end
    tick(1);
    chk(fin, 1'b0, tag);
  endtask

  task automatic t_reset;
    tick(3);
    chk(P_OFF, 1'b0, "R1 reset");
  endtask

  task automatic t_startup;
    req_lvl = 2'b00;
    dead_cycles = 8'd3;
    rst_n = 1'b1;
    tick(1);
    chk(4'b0100, 1'b1, "R2 startup q3 first");
    tick(2);
    chk(4'b0100, 1'b1, "R2 startup gap");
    tick(1);
    chk(P_NEU, 1'b0, "R2 startup neutral");
  endtask

  task automatic t_basic;
    move(2'b01, 2, 4'b0100, P_POS, "R4 neu->pos");
    move(2'b00, 4, 4'b0100, P_NEU, "R3 pos->neu");
    move(2'b10, 1, 4'b1000, P_NEG, "R5 neu->neg");
    move(2'b11, 2, 4'b1000, P_NEU, "R6 R10 neg->neu code 11");
    tick(4);
    chk(P_NEU, 1'b0, "R9 hold at level");
  endtask

  task automatic t_rail_to_rail;
    move(2'b01, 1, 4'b0100, P_POS, "R7 setup pos");
    move(2'b10, 2, 4'b0100, P_NEU, "R7 pos->neg step1");
    move(2'b10, 2, 4'b1000, P_NEG, "R7 pos->neg step2");
    move(2'b01, 1, 4'b1000, P_NEU, "R7 neg->pos step1");
    move(2'b01, 1, 4'b0100, P_POS, "R7 neg->pos step2");
  endtask

  task automatic t_latch;
    move(2'b00, 0, 4'b0100, P_NEU, "R8 zero dead time");
    req_lvl = 2'b01;
    dead_cycles = 8'd3;
    tick(1);
    chk(4'b0100, 1'b1, "R8 latch start");
    dead_cycles = 8'd1;
    req_lvl = 2'b10;
    tick(1);
    chk(4'b0100, 1'b1, "R9 request ignored while busy");
    tick(1);
    chk(4'b0100, 1'b1, "R8 captured delay kept");
    req_lvl = 2'b01;
    tick(1);
    chk(P_POS, 1'b0, "R8 R9 original target reached");
  endtask

  task automatic t_force;
    req_lvl = 2'b00;
    dead_cycles = 8'd5;
    tick(2);
    chk(4'b0100, 1'b1, "R3 move in progress");
    force_off = 1'b1;
    tick(1);
    chk(P_OFF, 1'b0, "R1 force mid-sequence");
    tick(3);
    chk(P_OFF, 1'b0, "R1 force held");
    dead_cycles = 8'd2;
    force_off = 1'b0;
    tick(1);
    chk(4'b0100, 1'b1, "R2 restart q3");
    tick(1);
    chk(4'b0100, 1'b1, "R2 restart gap");
    tick(1);
    chk(P_NEU, 1'b0, "R2 restart neutral");
    force_off = 1'b1;
    tick(1);
    chk(P_OFF, 1'b0, "R1 force from neutral");
    force_off = 1'b0;
    rst_n = 1'b0;
    tick(2);
    chk(P_OFF, 1'b0, "R1 reset after force");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_basic();
    t_rail_to_rail();
    t_latch();
    t_force();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule